// File: doc/BRIEF.md
# Overlay Display List Sequencer

This block walks a chain of overlay region descriptors once per video field. Software keeps one list pointer for each of the two fields. It writes these pointers through a small write port, and each write is staged until the next field begins. When a field-start pulse arrives, the sequencer takes the pointer of the field it names. It reads a four-beat, 128-bit region header from memory, starting at that address, and keeps the header in private registers that software cannot reach.

After the header is in place, the sequencer watches the display line counter. Once the counter reaches the region's first line, it presents a bitmap fetch request that carries the region's bitmap address and its bounds. When that request is taken, one of two things happens. If the header marks the region as the last one, the walk stops for that field. If not, the sequencer follows the header's link to the next header. Memory reads and bitmap fetches both use a valid/ready handshake.

Top module: `ovl_list_seq`

## Requirements
- R1: While reset is held, and after it is released until the first field-start pulse, `rd_valid` and `fetch_valid` are both 0.
- R2: One cycle after a field-start pulse, `rd_addr` equals the pointer last stored for the field named by `field_id`. A host write with `host_field` 0 or 1 stores `host_ptr` for that field.
- R3: A header is read as four 32-bit beats, at the base address plus 0, 4, 8 and 12. A beat is taken only in a cycle with `rd_valid` and `rd_ready` both high. Until it is taken, `rd_valid` stays high and `rd_addr` holds.
- R4: The header uses this layout. Beat 0 holds the first line in bits [9:0] and the last line in bits [25:16]. Beat 1 holds the first pixel in bits [11:0] and the last pixel in bits [27:16]. Beat 2 holds the bitmap address in bits [23:0]. Beat 3 holds the next-header pointer in bits [23:0] and the last-region flag in bit 31. While `fetch_valid` is high, the fetch outputs carry these values.
- R5: After the fourth beat, `fetch_valid` stays 0 until a cycle in which `disp_line` is greater than or equal to the region's first line. It rises in the next cycle.
- R6: `fetch_valid` and `fetch_addr` hold until `fetch_ready`. After the fetch is accepted, a set last-region flag stops all requests until the next field start. A clear flag starts a new header read at the next-header pointer in the next cycle.
- R7: A field-start pulse in any state aborts the current work. In the next cycle, beat 0 of the new field's list is requested.
- R8: A pointer write never changes the field in progress. A write made in the same cycle as a field-start pulse is first used at the following field start.
- R9: `rd_valid` and `fetch_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Field pointer write strobe |
| host_field | input | 1 | Field whose pointer is written |
| host_ptr | input | 24 | Pointer value to store |
| field_start | input | 1 | One-cycle pulse at the start of a field |
| field_id | input | 1 | Field that is starting |
| disp_line | input | 10 | Current display line |
| rd_valid | output | 1 | Header beat read request |
| rd_addr | output | 24 | Byte address of the requested beat |
| rd_ready | input | 1 | Memory accepts the request and returns data |
| rd_data | input | 32 | Header beat data, valid while rd_ready is high |
| fetch_valid | output | 1 | Bitmap fetch request |
| fetch_addr | output | 24 | Bitmap start address |
| fetch_start_line | output | 10 | First line of the region |
| fetch_end_line | output | 10 | Last line of the region |
| fetch_start_px | output | 12 | First pixel of the region |
| fetch_end_px | output | 12 | Last pixel of the region |
| fetch_ready | input | 1 | Fetch engine accepts the request |

## Verification
A wrong state or beat count appears at the ports within one cycle. It shows up as a read request that is missing or extra, a read address that is off by one beat, or a fetch request that comes too early or too late. A corrupted header register stays hidden until the fetch request, and then it shows as a wrong bitmap address or a wrong bound, or as a walk that follows the wrong link or stops too early. A reference model that tracks every handshake is compared on every clock, so any such fault is reported in the first cycle where it reaches an output.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOAD_HDR  = 3'd1,
    ST_WAIT_LINE = 3'd2,
    ST_FETCH     = 3'd3,
    ST_DONE      = 3'd4
  } ovl_state_e;

  localparam int HDR_BEATS  = 4;
  localparam int BEAT_W     = 32;
  localparam int BEAT_IDX_W = $clog2(HDR_BEATS);
  localparam int BEAT_BYTES = BEAT_W / 8;
  localparam int BYTE_SH    = $clog2(BEAT_BYTES);

  // bit positions inside the header beats
  localparam int SLINE_LSB  = 0;
  localparam int ELINE_LSB  = 16;
  localparam int SPX_LSB    = 0;
  localparam int EPX_LSB    = 16;
  localparam int LAST_BIT   = 31;

endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/ovl_ptr_bank.sv
module ovl_ptr_bank #(
  parameter int AW         = 24,
  parameter int NUM_FIELDS = 2,
  localparam int FIELD_W   = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_sel,
  input  logic [AW-1:0]      wr_ptr,
  input  logic [FIELD_W-1:0] rd_sel,
  output logic [AW-1:0]      rd_ptr
);

  logic [AW-1:0] ptr_q [NUM_FIELDS];

  // staged pointers: the sequencer samples them only on a field start
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic load_en;
    assign load_en = wr_en && (wr_sel == FIELD_W'(f));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[f] <= '0;
      end else if (load_en) begin
        ptr_q[f] <= wr_ptr;
      end
    end
  end

  assign rd_ptr = ptr_q[rd_sel];

endmodule

// File: rtl/ovl_hdr_regs.sv
module ovl_hdr_regs
  import ovl_pkg::*;
#(
  parameter int AW     = 24,
  parameter int LINE_W = 10,
  parameter int PIX_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  beat_acc,
  input  logic [BEAT_IDX_W-1:0] beat_idx,
  input  logic [BEAT_W-1:0]     beat_data,
  output logic [LINE_W-1:0]     start_line,
  output logic [LINE_W-1:0]     end_line,
  output logic [PIX_W-1:0]      start_px,
  output logic [PIX_W-1:0]      end_px,
  output logic [AW-1:0]         bm_addr,
  output logic [AW-1:0]         next_ptr,
  output logic                  last_flag
);

  logic [HDR_BEATS-1:0][BEAT_W-1:0] raw_q;
  logic                             hdr_unused;

  for (genvar b = 0; b < HDR_BEATS; b++) begin : g_beat
    logic cap_en;
    assign cap_en = beat_acc && (beat_idx == BEAT_IDX_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[b] <= '0;
      end else if (cap_en) begin
        raw_q[b] <= beat_data;
      end
    end
  end

  assign start_line = raw_q[0][SLINE_LSB +: LINE_W];
  assign end_line   = raw_q[0][ELINE_LSB +: LINE_W];
  assign start_px   = raw_q[1][SPX_LSB +: PIX_W];
  assign end_px     = raw_q[1][EPX_LSB +: PIX_W];
  assign bm_addr    = raw_q[2][AW-1:0];
  assign next_ptr   = raw_q[3][AW-1:0];
  assign last_flag  = raw_q[3][LAST_BIT];

  // reserved header bits are stored but carry no meaning
  assign hdr_unused = ^raw_q;

endmodule

// File: rtl/ovl_seq_fsm.sv
module ovl_seq_fsm
  import ovl_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  field_start,
  input  logic [AW-1:0]         field_ptr,
  input  logic                  rd_ready,
  input  logic                  line_hit,
  input  logic                  fetch_ready,
  input  logic                  last_flag,
  input  logic [AW-1:0]         next_ptr,
  output logic                  rd_valid,
  output logic [AW-1:0]         rd_addr,
  output logic                  beat_acc,
  output logic [BEAT_IDX_W-1:0] beat_idx,
  output logic                  fetch_valid
);

  localparam int OFS_W = BEAT_IDX_W + BYTE_SH;
  localparam logic [BEAT_IDX_W-1:0] LAST_BEAT = BEAT_IDX_W'(HDR_BEATS - 1);

  ovl_state_e            state_q, state_d;
  logic [BEAT_IDX_W-1:0] beat_q, beat_d;
  logic [AW-1:0]         base_q, base_d;
  logic                  fetch_acc;

  assign rd_valid    = (state_q == ST_LOAD_HDR);
  assign fetch_valid = (state_q == ST_FETCH);
  assign beat_acc    = rd_valid && rd_ready && !field_start;
  assign fetch_acc   = fetch_valid && fetch_ready && !field_start;
  assign beat_idx    = beat_q;
  assign rd_addr     = base_q + AW'({beat_q, {BYTE_SH{1'b0}}} & {OFS_W{1'b1}});

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    base_d  = base_q;
    if (field_start) begin
      state_d = ST_LOAD_HDR;
      beat_d  = '0;
      base_d  = field_ptr;
    end else begin
      unique case (state_q)
        ST_LOAD_HDR: begin
          if (beat_acc) begin
            if (beat_q == LAST_BEAT) begin
              state_d = ST_WAIT_LINE;
            end else begin
              beat_d = beat_q + 1'b1;
            end
          end
        end
        ST_WAIT_LINE: begin
          if (line_hit) begin
            state_d = ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fetch_acc) begin
            if (last_flag) begin
              state_d = ST_DONE;
            end else begin
              state_d = ST_LOAD_HDR;
              beat_d  = '0;
              base_d  = next_ptr;
            end
          end
        end
        ST_IDLE, ST_DONE: begin
          state_d = state_q;
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      base_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      base_q  <= base_d;
    end
  end

endmodule

// File: rtl/ovl_list_seq.sv
module ovl_list_seq
  import ovl_pkg::*;
#(
  parameter int AW         = 24,
  parameter int LINE_W     = 10,
  parameter int PIX_W      = 12,
  parameter int NUM_FIELDS = 2,
  localparam int FIELD_W   = (NUM_FIELDS > 1) ? $clog2(NUM_FIELDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_we,
  input  logic [FIELD_W-1:0] host_field,
  input  logic [AW-1:0]      host_ptr,
  input  logic               field_start,
  input  logic [FIELD_W-1:0] field_id,
  input  logic [LINE_W-1:0]  disp_line,
  output logic               rd_valid,
  output logic [AW-1:0]      rd_addr,
  input  logic               rd_ready,
  input  logic [BEAT_W-1:0]  rd_data,
  output logic               fetch_valid,
  output logic [AW-1:0]      fetch_addr,
  output logic [LINE_W-1:0]  fetch_start_line,
  output logic [LINE_W-1:0]  fetch_end_line,
  output logic [PIX_W-1:0]   fetch_start_px,
  output logic [PIX_W-1:0]   fetch_end_px,
  input  logic               fetch_ready
);

  logic                  rst_sync_n;
  logic [AW-1:0]         field_ptr;
  logic [AW-1:0]         next_ptr;
  logic                  last_flag;
  logic                  line_hit;
  logic                  beat_acc;
  logic [BEAT_IDX_W-1:0] beat_idx;

  ovl_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ovl_ptr_bank #(
    .AW         (AW),
    .NUM_FIELDS (NUM_FIELDS)
  ) u_ptr_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (host_we),
    .wr_sel (host_field),
    .wr_ptr (host_ptr),
    .rd_sel (field_id),
    .rd_ptr (field_ptr)
  );

  ovl_hdr_regs #(
    .AW     (AW),
    .LINE_W (LINE_W),
    .PIX_W  (PIX_W)
  ) u_hdr_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .beat_acc   (beat_acc),
    .beat_idx   (beat_idx),
    .beat_data  (rd_data),
    .start_line (fetch_start_line),
    .end_line   (fetch_end_line),
    .start_px   (fetch_start_px),
    .end_px     (fetch_end_px),
    .bm_addr    (fetch_addr),
    .next_ptr   (next_ptr),
    .last_flag  (last_flag)
  );

  assign line_hit = (disp_line >= fetch_start_line);

  ovl_seq_fsm #(
    .AW (AW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .field_start (field_start),
    .field_ptr   (field_ptr),
    .rd_ready    (rd_ready),
    .line_hit    (line_hit),
    .fetch_ready (fetch_ready),
    .last_flag   (last_flag),
    .next_ptr    (next_ptr),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr),
    .beat_acc    (beat_acc),
    .beat_idx    (beat_idx),
    .fetch_valid (fetch_valid)
  );

endmodule

// File: rtl/ovl_list_seq_chk.sv
module ovl_list_seq_chk
  import ovl_pkg::*;
#(
  parameter int AW     = 24,
  parameter int LINE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  field_start,
  input  logic                  rd_valid,
  input  logic                  rd_ready,
  input  logic [AW-1:0]         rd_addr,
  input  logic                  fetch_valid,
  input  logic                  fetch_ready,
  input  logic [AW-1:0]         fetch_addr,
  input  logic [LINE_W-1:0]     fetch_start_line,
  input  logic [LINE_W-1:0]     disp_line,
  input  logic [BEAT_IDX_W-1:0] beat_idx
);

  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && fetch_valid)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !field_start |=> rd_valid && $stable(rd_addr)); // R3

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !field_start && (beat_idx != BEAT_IDX_W'(HDR_BEATS - 1))
    |=> rd_valid && ((rd_addr - $past(rd_addr)) == AW'(BEAT_BYTES))); // R3

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready && !field_start |=> fetch_valid && $stable(fetch_addr)); // R6

  AST_LINE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_valid) |-> ($past(disp_line) >= fetch_start_line)); // R5

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> rd_valid && (beat_idx == '0)); // R7

endmodule

bind ovl_list_seq ovl_list_seq_chk #(
  .AW     (AW),
  .LINE_W (LINE_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .field_start      (field_start),
  .rd_valid         (rd_valid),
  .rd_ready         (rd_ready),
  .rd_addr          (rd_addr),
  .fetch_valid      (fetch_valid),
  .fetch_ready      (fetch_ready),
  .fetch_addr       (fetch_addr),
  .fetch_start_line (fetch_start_line),
  .disp_line        (disp_line),
  .beat_idx         (beat_idx)
);

// File: tb/ovl_list_seq_tb.sv
module ovl_list_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic        host_field;
  logic [23:0] host_ptr;
  logic        field_start;
  logic        field_id;
  logic [9:0]  disp_line;
  logic        rd_valid;
  logic [23:0] rd_addr;
  logic        rd_ready;
  logic [31:0] rd_data;
  logic        fetch_valid;
  logic [23:0] fetch_addr;
  logic [9:0]  fetch_start_line;
  logic [9:0]  fetch_end_line;
  logic [11:0] fetch_start_px;
  logic [11:0] fetch_end_px;
  logic        fetch_ready;

  int checks;
  int errors;
  bit done;
  bit cmp_en;
  logic [15:0] lfsr;

  logic [31:0] mem [0:255];
  assign rd_data = mem[rd_addr[9:2]];

  ovl_list_seq u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .host_we          (host_we),
    .host_field       (host_field),
    .host_ptr         (host_ptr),
    .field_start      (field_start),
    .field_id         (field_id),
    .disp_line        (disp_line),
    .rd_valid         (rd_valid),
    .rd_addr          (rd_addr),
    .rd_ready         (rd_ready),
    .rd_data          (rd_data),
    .fetch_valid      (fetch_valid),
    .fetch_addr       (fetch_addr),
    .fetch_start_line (fetch_start_line),
    .fetch_end_line   (fetch_end_line),
    .fetch_start_px   (fetch_start_px),
    .fetch_end_px     (fetch_end_px),
    .fetch_ready      (fetch_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // m_st: 0 idle, 1 loading header, 2 waiting for line, 3 fetch, 4 done
  int          m_st;
  int          m_beat;
  logic [23:0] m_base;
  logic [23:0] m_ptr [2];
  logic [31:0] m_hdr [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_beat = 0; m_base = '0;
      m_ptr[0] = '0; m_ptr[1] = '0;
      for (int i = 0; i < 4; i++) m_hdr[i] = '0;
    end else begin
      if (field_start) begin
        m_st = 1; m_beat = 0; m_base = m_ptr[field_id];
      end else if (m_st == 1) begin
        if (rd_ready) begin
          logic [23:0] a;
          a = m_base + 24'(4 * m_beat);
          m_hdr[m_beat] = mem[a[9:2]];
          if (m_beat == 3) m_st = 2;
          else m_beat++;
        end
      end else if (m_st == 2) begin
        if (int'(disp_line) >= int'(m_hdr[0][9:0])) m_st = 3;
      end else if (m_st == 3) begin
        if (fetch_ready) begin
          if (m_hdr[3][31]) m_st = 4;
          else begin
            m_st = 1; m_beat = 0; m_base = m_hdr[3][23:0];
          end
        end
      end
      if (host_we) m_ptr[host_field] = host_ptr;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk(rd_valid == (m_st == 1), "R3 rd_valid", 32'(rd_valid), 32'(m_st == 1));
      if (m_st == 1)
        chk(rd_addr == m_base + 24'(4 * m_beat), "R3 rd_addr", 32'(rd_addr), 32'(m_base + 24'(4 * m_beat)));
      chk(fetch_valid == (m_st == 3), "R5 fetch_valid", 32'(fetch_valid), 32'(m_st == 3));
      if (m_st == 3) begin
        chk(fetch_addr == m_hdr[2][23:0], "R4 fetch_addr", 32'(fetch_addr), 32'(m_hdr[2][23:0]));
        chk(fetch_start_line == m_hdr[0][9:0], "R4 start_line", 32'(fetch_start_line), 32'(m_hdr[0][9:0]));
        chk(fetch_end_line == m_hdr[0][25:16], "R4 end_line", 32'(fetch_end_line), 32'(m_hdr[0][25:16]));
        chk(fetch_start_px == m_hdr[1][11:0], "R4 start_px", 32'(fetch_start_px), 32'(m_hdr[1][11:0]));
        chk(fetch_end_px == m_hdr[1][27:16], "R4 end_px", 32'(fetch_end_px), 32'(m_hdr[1][27:16]));
      end
      if (m_st == 4)
        chk(!rd_valid && !fetch_valid, "R6 stopped after last region",
            32'({rd_valid, fetch_valid}), 32'(0));
      chk(!(rd_valid && fetch_valid), "R9 exclusive requests", 32'({rd_valid, fetch_valid}), 32'(0));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put_hdr(input int addr, input int sl, input int el, input int sp, input int ep,
                         input int bm, input int nxt, input bit last);
    mem[addr / 4 + 0] = (32'(el) << 16) | 32'(sl);
    mem[addr / 4 + 1] = (32'(ep) << 16) | 32'(sp);
    mem[addr / 4 + 2] = 32'(bm) & 32'h00FF_FFFF;
    mem[addr / 4 + 3] = {last, 7'd0, 24'(nxt)};
  endtask

  task automatic tick();
    @(negedge clk);
    lfsr        = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_ready    = lfsr[0] | lfsr[3];
    fetch_ready = lfsr[5];
    host_we     = 1'b0;
    disp_line   = disp_line + 10'd1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic write_ptr(input bit f, input int p);
    host_we = 1'b1; host_field = f; host_ptr = 24'(p);
    tick();
  endtask

  // pulse a field start; optionally write a pointer in the same cycle
  task automatic start_field(input bit f, input bit wr, input bit wf, input int wp,
                             input int exp_addr, input string tag);
    field_start = 1'b1; field_id = f; disp_line = '0;
    host_we = wr; host_field = wf; host_ptr = 24'(wp);
    @(negedge clk);
    field_start = 1'b0; host_we = 1'b0;
    chk(rd_valid && rd_addr == 24'(exp_addr), tag, 32'(rd_addr), 32'(exp_addr));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    checks = 0; errors = 0; done = 0; cmp_en = 0;
    lfsr = 16'hACE1;
    rst_n = 1'b0; host_we = 1'b0; host_field = 1'b0; host_ptr = '0;
    field_start = 1'b0; field_id = 1'b0; disp_line = '0;
    rd_ready = 1'b0; fetch_ready = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | 32'(i);

    // field 0 list: two regions; field 1: one region; spare lists at 0xC0, 0x140
    put_hdr(32'h040, 20, 40, 16, 300, 32'h01_2000, 32'h080, 1'b0);
    put_hdr(32'h080, 50, 70, 100, 700, 32'h01_8000, 32'h000, 1'b1);
    put_hdr(32'h100, 5, 9, 0, 719, 32'h02_0000, 32'h000, 1'b1);
    put_hdr(32'h0C0, 30, 31, 7, 8, 32'h03_0000, 32'h000, 1'b1);
    put_hdr(32'h140, 0, 1000, 4095, 1, 32'hFF_FFFC, 32'h000, 1'b1);

    repeat (3) @(negedge clk);
    chk(!rd_valid && !fetch_valid, "R1 reset outputs", 32'({rd_valid, fetch_valid}), 32'(0));
    rst_n = 1'b1;
    run(5);
    chk(!rd_valid && !fetch_valid, "R1 idle before field start", 32'({rd_valid, fetch_valid}), 32'(0));
    cmp_en = 1;

    write_ptr(1'b0, 32'h040);
    write_ptr(1'b1, 32'h100);
    run(3);
    chk(!rd_valid, "R1 pointer writes alone start nothing", 32'(rd_valid), 32'(0));

    // field 0: two linked regions
    start_field(1'b0, 1'b0, 1'b0, 0, 32'h040, "R2 field 0 first beat address");
    run(200);
    chk(!rd_valid && !fetch_valid, "R6 walk ended after last flag", 32'({rd_valid, fetch_valid}), 32'(0));

    // field 1: single region
    start_field(1'b1, 1'b0, 1'b0, 0, 32'h100, "R2 field 1 first beat address");
    run(60);

    // R8: mid-field write does not disturb the running walk
    start_field(1'b0, 1'b0, 1'b0, 0, 32'h040, "R2 field 0 again");
    run(3);
    write_ptr(1'b0, 32'h0C0);
    run(20);
    // R7 restart in mid-walk; R8 same-cycle write not used yet
    start_field(1'b0, 1'b1, 1'b0, 32'h140, 32'h0C0, "R8 staged pointer used at next field start");
    run(100);
    start_field(1'b0, 1'b0, 1'b0, 0, 32'h140, "R8 same-cycle write used one field later");
    run(40);

    // R7: restart while a header is loading
    start_field(1'b1, 1'b0, 1'b0, 0, 32'h100, "R7 field 1 start");
    start_field(1'b0, 1'b0, 1'b0, 0, 32'h140, "R7 restart during header load");
    run(60);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule